// File: doc/BRIEF.md
# Condition-Addressed Microcode Sequencer

This block steps a microcoded 8-bit processor through the micro-instructions of each machine instruction. Every cycle it forms a micro-ROM address from three registered sources: the opcode of the instruction in progress, a 4-bit phase count within that instruction, and the 4-bit condition-code register. Because the condition codes are address bits, each phase of each opcode owns sixteen micro-word slots, one per condition combination. The value of the flags therefore picks which single variant runs at that phase, without any branch logic in the sequencer.

The micro-ROM sits outside the block: the sequencer drives the address and receives the 16-bit micro-word back in the same cycle. The word tells it which condition bits to reload from the datapath flags, which of four address/register destinations to enable, eight general control bits to pass on, and whether the instruction ends here. On the end mark, or when the phase count reaches its last value, the phase returns to zero and the next opcode is captured. A relative branch can use this to add an extra micro-step only when adding the offset carries into the upper program-counter byte: one phase reloads the address-carry bit, and the next phase's word differs by that bit.

Top module: `useq_core`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `phase`, `opcode`, `ccr`, `dst_en`, `ctrl` and `instr_done` all zero.
- R2: `urom_addr` equals `{opcode, phase, ccr}` (opcode in bits 15:8, phase in 7:4, condition codes in 3:0) in the same cycle those registers change, with no added register stage.
- R3: Micro-word layout is bits 15:8 control, 7:4 condition-load mask, 3 end-of-instruction, 2 destination-valid, 1:0 destination select. When bit 3 is 0 and `phase` is below 15, `phase` rises by one at the edge.
- R4: When the word's end bit is 1, the next `phase` is 0 and `opcode` takes `op_in`; in every other case apart from R5, `opcode` holds whatever `op_in` carries.
- R5: When `phase` is 15 and the end bit is 0, the block still restarts: next `phase` is 0 and `opcode` takes `op_in`.
- R6: Condition bit i (0 carry, 1 zero, 2 negative, 3 address carry) loads `flag_in[i]` at the edge when load-mask bit i is 1, and holds otherwise, whatever `flag_in` carries.
- R7: One cycle after a word with destination-valid 1 is applied, `dst_en` has only the bit numbered by the select field set; after a word with destination-valid 0, `dst_en` is zero.
- R8: One cycle after a word is applied, `ctrl` shows its control field, and `instr_done` is 1 exactly when that word ended the instruction by R4 or R5.
- R9: The word applied at a phase is the one addressed by the condition bits loaded at the previous edge, so the same opcode and phase run different variants (here a branch with one extra step when address carry is 1) under different condition values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | 8 | Next opcode, captured when an instruction ends |
| flag_in | input | 4 | Flags from the datapath, candidates for the condition register |
| urom_word | input | 16 | Micro-word returned by the micro-ROM for `urom_addr` |
| urom_addr | output | 16 | Micro-ROM address `{opcode, phase, ccr}` |
| phase | output | 4 | Current micro-step index |
| opcode | output | 8 | Opcode of the instruction in progress |
| ccr | output | 4 | Condition-code register |
| dst_en | output | 4 | Registered one-hot destination enable strobes |
| ctrl | output | 8 | Registered control field of the last applied word |
| instr_done | output | 1 | Registered flag: the last applied word ended an instruction |

## Verification
The assertions take the micro-word to be a pure combinational function of `urom_addr` that settles within the cycle and carries no unknown bits, and take `op_in` and `flag_in` to be steady across each rising edge. The bench meets this by computing the word from the address in a function with a continuous assignment, and by changing `op_in` and `flag_in` only a quarter period after each edge. Its micro-program drives a flag-loading opcode, a branch taken both with and without address carry, and an opcode that never sets the end bit, so the phase-15 restart is reached.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OPC_W  = 8;
    localparam int PH_W   = 4;
    localparam int CC_W   = 4;
    localparam int CTRL_W = 8;
    localparam int DST_N  = 4;
    localparam int DSEL_W = $clog2(DST_N);
    localparam int ADDR_W = OPC_W + PH_W + CC_W;

    localparam logic [PH_W-1:0] PH_LAST = '1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CC_W-1:0]   cc_ld;
        logic              eoi;
        logic              dst_vld;
        logic [DSEL_W-1:0] dst_sel;
    } uword_t;

    localparam int UW_W = $bits(uword_t);

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [PH_W-1:0]  ph;
        logic [CC_W-1:0]  cc;
    } uaddr_t;

    function automatic logic [DST_N-1:0] sel_to_hot(input logic vld,
                                                     input logic [DSEL_W-1:0] sel);
        logic [DST_N-1:0] h;
        h = '0;
        if (vld) h[sel] = 1'b1;
        return h;
    endfunction

endpackage

// File: rtl/useq_addr_gen.sv
module useq_addr_gen
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode,
    input  logic [PH_W-1:0]   phase,
    input  logic [CC_W-1:0]   ccr,
    output logic [ADDR_W-1:0] addr
);
    uaddr_t a;

    always_comb begin
        a.opc = opcode;
        a.ph  = phase;
        a.cc  = ccr;
    end

    assign addr = a;
endmodule

// File: rtl/useq_step_ctl.sv
module useq_step_ctl
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eoi,
    input  logic [OPC_W-1:0] op_in,
    output logic [PH_W-1:0]  phase,
    output logic [OPC_W-1:0] opcode,
    output logic             restart
);
    // An instruction ends on its own mark or when the phase space runs out.
    assign restart = eoi || (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            opcode <= '0;
        end else if (restart) begin
            phase  <= '0;
            opcode <= op_in;
        end else begin
            phase  <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/useq_cc_reg.sv
module useq_cc_reg
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CC_W-1:0] ld_mask,
    input  logic [CC_W-1:0] flag_in,
    output logic [CC_W-1:0] ccr
);
    for (genvar i = 0; i < CC_W; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst)             q <= 1'b0;
            else if (ld_mask[i]) q <= flag_in[i];
        end
        assign ccr[i] = q;
    end
endmodule

// File: rtl/useq_dst_dec.sv
module useq_dst_dec
    import useq_pkg::*;
(
    input  logic              vld,
    input  logic [DSEL_W-1:0] sel,
    output logic [DST_N-1:0]  hot
);
    for (genvar i = 0; i < DST_N; i++) begin : g_line
        assign hot[i] = vld && (sel == DSEL_W'(i));
    end
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  op_in,
    input  logic [CC_W-1:0]   flag_in,
    input  logic [UW_W-1:0]   urom_word,
    output logic [ADDR_W-1:0] urom_addr,
    output logic [PH_W-1:0]   phase,
    output logic [OPC_W-1:0]  opcode,
    output logic [CC_W-1:0]   ccr,
    output logic [DST_N-1:0]  dst_en,
    output logic [CTRL_W-1:0] ctrl,
    output logic              instr_done
);
    uword_t           w;
    logic             restart;
    logic [DST_N-1:0] hot;

    assign w = uword_t'(urom_word);

    useq_addr_gen u_addr (
        .opcode (opcode),
        .phase  (phase),
        .ccr    (ccr),
        .addr   (urom_addr)
    );

    useq_step_ctl u_step (
        .clk     (clk),
        .rst     (rst),
        .eoi     (w.eoi),
        .op_in   (op_in),
        .phase   (phase),
        .opcode  (opcode),
        .restart (restart)
    );

    useq_cc_reg u_cc (
        .clk     (clk),
        .rst     (rst),
        .ld_mask (w.cc_ld),
        .flag_in (flag_in),
        .ccr     (ccr)
    );

    useq_dst_dec u_dec (
        .vld (w.dst_vld),
        .sel (w.dst_sel),
        .hot (hot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_en     <= '0;
            ctrl       <= '0;
            instr_done <= 1'b0;
        end else begin
            dst_en     <= hot;
            ctrl       <= w.ctrl;
            instr_done <= restart;
        end
    end
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OPC_W-1:0]  op_in,
    input logic [CC_W-1:0]   flag_in,
    input logic [UW_W-1:0]   urom_word,
    input logic [ADDR_W-1:0] urom_addr,
    input logic [PH_W-1:0]   phase,
    input logic [OPC_W-1:0]  opcode,
    input logic [CC_W-1:0]   ccr,
    input logic [DST_N-1:0]  dst_en,
    input logic [CTRL_W-1:0] ctrl,
    input logic              instr_done
);
    uword_t w;
    logic   ends;
    assign w    = uword_t'(urom_word);
    assign ends = w.eoi || (phase == PH_LAST);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (phase == '0 && opcode == '0 && ccr == '0 && dst_en == '0
                 && ctrl == '0 && !instr_done));                               // R1
    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (rst)
        urom_addr[CC_W-1:0] == ccr && urom_addr[ADDR_W-1:ADDR_W-OPC_W] == opcode
        && urom_addr[CC_W+PH_W-1:CC_W] == phase);                              // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!w.eoi && phase != PH_LAST) |=> phase == $past(phase) + 1'b1);        // R3
    AST_EOI_LOAD: assert property (@(posedge clk) disable iff (rst)
        w.eoi |=> (phase == '0 && opcode == $past(op_in)));                     // R4
    AST_OPC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ends |=> $stable(opcode));                                             // R4
    AST_PHASE_CAP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LAST) |=> (phase == '0 && opcode == $past(op_in)));        // R5
    AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (w.cc_ld == '0) |=> $stable(ccr));                                      // R6
    AST_CC_LOAD: assert property (@(posedge clk) disable iff (rst)
        (w.cc_ld == '1) |=> ccr == $past(flag_in));                             // R6
    AST_DST_STROBE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> dst_en == sel_to_hot($past(w.dst_vld), $past(w.dst_sel)));     // R7
    AST_DST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dst_en));                                                      // R7
    AST_CTRL_PASS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ctrl == $past(w.ctrl) && instr_done == $past(ends)));          // R8
endmodule

bind useq_core useq_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_in      (op_in),
    .flag_in    (flag_in),
    .urom_word  (urom_word),
    .urom_addr  (urom_addr),
    .phase      (phase),
    .opcode     (opcode),
    .ccr        (ccr),
    .dst_en     (dst_en),
    .ctrl       (ctrl),
    .instr_done (instr_done)
);

// File: tb/useq_core_tb.sv
module useq_core_tb;
    import useq_pkg::*;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [OPC_W-1:0]  op_in = '0;
    logic [CC_W-1:0]   flag_in = '0;
    logic [UW_W-1:0]   urom_word;
    logic [ADDR_W-1:0] urom_addr;
    logic [PH_W-1:0]   phase;
    logic [OPC_W-1:0]  opcode;
    logic [CC_W-1:0]   ccr;
    logic [DST_N-1:0]  dst_en;
    logic [CTRL_W-1:0] ctrl;
    logic              instr_done;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    // Micro-program: 00 one-step, 10 loads all flags then ends,
    // 20 branch (extra step when address carry set), 30 never ends.
    function automatic uword_t rom_fn(input logic [ADDR_W-1:0] a);
        uword_t r;
        logic [7:0] op;
        logic [3:0] ph;
        logic [3:0] cc;
        op = a[15:8]; ph = a[7:4]; cc = a[3:0];
        r.ctrl    = {ph, cc};
        r.dst_sel = ph[1:0];
        r.dst_vld = (op != 8'h00);
        r.cc_ld   = 4'h0;
        r.eoi     = 1'b0;
        case (op)
            8'h10: begin
                if (ph == 4'd0) r.cc_ld = 4'hF;
                r.eoi = (ph == 4'd1);
            end
            8'h20: begin
                if (ph == 4'd0) r.cc_ld = 4'b1000;
                if (ph == 4'd1) r.eoi = !cc[3];
                if (ph == 4'd2) r.eoi = 1'b1;
            end
            8'h30: r.eoi = 1'b0;
            default: r.eoi = 1'b1;
        endcase
        return r;
    endfunction

    assign urom_word = rom_fn(urom_addr);

    useq_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .op_in      (op_in),
        .flag_in    (flag_in),
        .urom_word  (urom_word),
        .urom_addr  (urom_addr),
        .phase      (phase),
        .opcode     (opcode),
        .ccr        (ccr),
        .dst_en     (dst_en),
        .ctrl       (ctrl),
        .instr_done (instr_done)
    );

    typedef struct packed {
        logic [7:0] op;
        logic [3:0] fl;
        logic [3:0] ph;
        logic [7:0] opc;
        logic [3:0] cc;
        logic [3:0] dst;
        logic [7:0] ctl;
        logic       done;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 4'h5, 4'h0, 8'h10, 4'h0, 4'b0000, 8'h00, 1'b1},
        '{8'h20, 4'h5, 4'h1, 8'h10, 4'h5, 4'b0001, 8'h00, 1'b0},
        '{8'h20, 4'hA, 4'h0, 8'h20, 4'h5, 4'b0010, 8'h15, 1'b1},
        '{8'h30, 4'h8, 4'h1, 8'h20, 4'hD, 4'b0001, 8'h05, 1'b0},
        '{8'h30, 4'h0, 4'h2, 8'h20, 4'hD, 4'b0010, 8'h1D, 1'b0},
        '{8'h20, 4'h0, 4'h0, 8'h20, 4'hD, 4'b0100, 8'h2D, 1'b1},
        '{8'h20, 4'h0, 4'h1, 8'h20, 4'h5, 4'b0001, 8'h0D, 1'b0},
        '{8'h30, 4'hF, 4'h0, 8'h30, 4'h5, 4'b0010, 8'h15, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] op, input logic [3:0] fl);
        op_in = op; flag_in = fl;
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic check_all(input string tag, input logic [3:0] ph, input logic [7:0] opc,
                             input logic [3:0] cc, input logic [3:0] dst,
                             input logic [7:0] ctl, input logic done);
        check({tag, " R3 phase"}, 32'(phase), 32'(ph));
        check({tag, " R4 opcode"}, 32'(opcode), 32'(opc));
        check({tag, " R6 ccr"}, 32'(ccr), 32'(cc));
        check({tag, " R7 dst_en"}, 32'(dst_en), 32'(dst));
        check({tag, " R8 ctrl"}, 32'(ctrl), 32'(ctl));
        check({tag, " R8 instr_done"}, 32'(instr_done), 32'(done));
        check({tag, " R2 urom_addr"}, 32'(urom_addr), 32'({opc, ph, cc}));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        rst = 1'b1;
        step(8'h00, 4'h0);
        step(8'h55, 4'hF);
        check_all("R1 reset", 4'h0, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0);
        rst = 1'b0;

        // Vector walk: flag load, branch with and without address carry (R9).
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].op, VECS[i].fl);
            check_all($sformatf("vec%0d", i), VECS[i].ph, VECS[i].opc, VECS[i].cc,
                      VECS[i].dst, VECS[i].ctl, VECS[i].done);
        end
        // R9: carry-set branch took three cycles (vec3..5), carry-clear two (vec6..7).

        // R5 and R4/R6 ignore: opcode 30 never ends; op_in and flag_in must not leak.
        for (int k = 1; k <= 15; k++) begin
            step(8'h77, 4'hF);
            check_all($sformatf("R5 run%0d", k), 4'(k), 8'h30, 4'h5,
                      4'(1 << ((k - 1) % 4)), {4'(k - 1), 4'h5}, 1'b0);
        end
        step(8'h00, 4'hA);
        check_all("R5 forced end", 4'h0, 8'h00, 4'h5, 4'b1000, 8'hF5, 1'b1);

        step(8'h10, 4'h0);
        check_all("R7 idle dst", 4'h0, 8'h10, 4'h5, 4'b0000, 8'h05, 1'b1);
        step(8'h00, 4'h3);
        check_all("R6 full load", 4'h1, 8'h10, 4'h3, 4'b0001, 8'h05, 1'b0);

        // R1: reset in mid-instruction.
        rst = 1'b1;
        step(8'h20, 4'hF);
        check_all("R1 mid reset", 4'h0, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0);
        rst = 1'b0;
        step(8'h10, 4'h0);
        check_all("R4 after reset", 4'h0, 8'h10, 4'h0, 4'h0, 8'h00, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule